// File: doc/BRIEF.md
# Dual-CPU Interrupt Routing Mapper

This block collects level-sensitive interrupt sources and presents them to two processors. Each processor has its own set of state. A mask vector blocks sources: a 1 blocks a source and a 0 lets it through. A map code for each source picks one of five interrupt output lines. The processor view also holds a 64-bit mailbox that software sets and clears by writing ones, and a latch vector for bridged interrupt events, which software clears by writing ones.

A source that is pending and unmasked on a processor drives the output line its map code names for that processor. A processor reads its status vector, or a ready-made "highest pending source" word, to choose what to service. Masking is separate for each processor, so the same source can be handed from one processor to the other. Software does this by masking the source on one side and unmasking it on the other.

Software reaches the block through a single 64-bit register port. The writes are strobed and the reads are combinational. Address bit 10 selects the processor window.

Top module: `irqmap_top`

## Requirements
- R1: After a synchronous reset, every mask bit reads 1, every map code reads 0, and the mailbox, latch and highest-pending word read 0. All output lines are low.
- R2: The mask lives at window offset 0x000 and can be read and written. A 1 in bit i blocks source i on that processor and a 0 passes it. The two processors' masks are independent.
- R3: The map code for source i lives at window offset 0x200 + 8*i. Only the low three bits are stored, and the other written bits are ignored. Code k from 0 to 4 routes the source to line k of that processor. Codes 5, 6 and 7 route it to no line.
- R4: Output line k of processor c is the OR of every source that is pending, unmasked on c, and mapped to k on c. Line k of processor c is port bit c*5+k. A change on `src_i` reaches the lines after exactly one clock edge.
- R5: The read-only word at offset 0x008 shows the pending sources that are not masked on that processor. A source is pending when its registered input is high, its latch bit is set, or (for source 26 only) the mailbox is nonzero.
- R6: The mailbox reads back at offset 0x010. A write to 0x018 sets the bits written as 1, and a write to 0x020 clears them. While any mailbox bit is set, source 26 is pending on that processor.
- R7: Each cycle in which `bridge_evt_i` bit i is high sets latch bit i on both processors. The latch reads back at offset 0x028. A write to 0x030 clears the bits written as 1 on that processor only. When a set and a clear reach the same bit in the same cycle, the set wins.
- R8: Address bit 10 selects processor 0 or 1. A write to one processor's window leaves the other processor's state unchanged. An access whose address bits 2:0 are not zero neither writes nor returns data.
- R9: The read-only word at offset 0x038 holds the number of the highest-numbered set status bit in bits 5:0, and a valid flag in bit 8. It reads 0 when the status is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Level-sensitive interrupt sources |
| bridge_evt_i | input | 64 | Bridged interrupt events, one cycle sets the latch bit |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 11 | Byte address: bit 10 processor, bits 9:0 offset |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data for reg_addr_i |
| irq_line_o | output | 10 | Output lines, bit c*5+k is line k of processor c |

## Verification
A software latch clear and a bridged event can hit the same latch bit in the same clock cycle. The bench provokes this by driving one event bit in the same cycle as a clear write that covers that bit and one other latched bit. It then reads the latch on both processors. The set bit must survive, the other bit must be cleared on the written processor only, and the other processor's latch must be untouched.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;

    localparam int unsigned REG_W = 64;
    localparam int unsigned IDX_W = 6;

    // control word index, taken from offset bits 5:3
    typedef enum logic [2:0] {
        CW_MASK      = 3'd0,
        CW_STATUS    = 3'd1,
        CW_MBOX      = 3'd2,
        CW_MBOX_SET  = 3'd3,
        CW_MBOX_CLR  = 3'd4,
        CW_LATCH     = 3'd5,
        CW_LATCH_CLR = 3'd6,
        CW_TOP       = 3'd7
    } ctl_word_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } top_pick_t;

    // highest-numbered set bit of a status vector
    function automatic top_pick_t pick_highest(input logic [REG_W-1:0] v);
        top_pick_t r;
        r = '0;
        for (int i = 0; i < int'(REG_W); i++) begin
            if (v[i]) begin
                r.valid = 1'b1;
                r.idx   = IDX_W'(i);
            end
        end
        return r;
    endfunction

    // read-back layout of the highest-pending word
    function automatic logic [REG_W-1:0] pack_pick(input top_pick_t p);
        logic [REG_W-1:0] w;
        w          = '0;
        w[8]       = p.valid;
        w[IDX_W-1:0] = p.idx;
        return w;
    endfunction

endpackage

// File: rtl/irqmap_route.sv
module irqmap_route #(
    parameter int NUM_SRC   = 64,
    parameter int NUM_LINES = 5,
    parameter int MAP_W     = 3
) (
    input  logic [NUM_SRC-1:0]       elig_i,
    input  logic [NUM_SRC*MAP_W-1:0] codes_i,
    output logic [NUM_LINES-1:0]     lines_o
);

    generate
        for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
            logic hit;
            always_comb begin
                hit = 1'b0;
                for (int i = 0; i < NUM_SRC; i++) begin
                    if (elig_i[i] && (codes_i[i*MAP_W +: MAP_W] == MAP_W'(k)))
                        hit = 1'b1;
                end
            end
            assign lines_o[k] = hit;
        end
    endgenerate

endmodule

// File: rtl/irqmap_cpu_slice.sv
module irqmap_cpu_slice
    import irqmap_pkg::*;
#(
    parameter int NUM_SRC   = 64,
    parameter int NUM_LINES = 5,
    parameter int MBOX_SRC  = 26,
    localparam int SRC_W    = $clog2(NUM_SRC),
    localparam int WIN_W    = SRC_W + 4,
    localparam int MAP_W    = $clog2(NUM_LINES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en_i,
    input  logic [WIN_W-1:0]     offset_i,
    input  logic [REG_W-1:0]     wdata_i,
    input  logic [NUM_SRC-1:0]   src_q_i,
    input  logic [NUM_SRC-1:0]   bridge_evt_i,
    output logic [REG_W-1:0]     rdata_o,
    output logic [NUM_SRC-1:0]   mask_o,
    output logic [REG_W-1:0]     mbox_o,
    output logic [NUM_SRC-1:0]   latch_o,
    output logic [NUM_SRC-1:0]   status_o,
    output logic [NUM_LINES-1:0] lines_o
);

    logic [NUM_SRC-1:0]       mask_q;
    logic [REG_W-1:0]         mbox_q;
    logic [NUM_SRC-1:0]       latch_q;
    logic [MAP_W-1:0]         map_q [NUM_SRC];
    logic [NUM_SRC*MAP_W-1:0] map_flat;

    logic                     aligned;
    logic                     map_sel;
    logic                     ctl_sel;
    ctl_word_e                cw;
    logic [SRC_W-1:0]         map_idx;

    logic [REG_W-1:0]         mbox_set, mbox_clr, mbox_nxt;
    logic [NUM_SRC-1:0]       latch_clr, latch_nxt;
    logic [NUM_SRC-1:0]       pending;
    logic [NUM_SRC-1:0]       status;
    top_pick_t                pick;

    // address decode
    assign aligned = (offset_i[2:0] == 3'b000);
    assign map_sel = aligned && offset_i[WIN_W-1];
    assign ctl_sel = aligned && !offset_i[WIN_W-1] && (offset_i[WIN_W-2:6] == '0);
    assign cw      = ctl_word_e'(offset_i[5:3]);
    assign map_idx = offset_i[3 +: SRC_W];

    // set / clear strobes
    always_comb begin
        mbox_set  = '0;
        mbox_clr  = '0;
        latch_clr = '0;
        if (wr_en_i && ctl_sel) begin
            unique case (cw)
                CW_MBOX_SET:  mbox_set  = wdata_i;
                CW_MBOX_CLR:  mbox_clr  = wdata_i;
                CW_LATCH_CLR: latch_clr = wdata_i[NUM_SRC-1:0];
                default: ;
            endcase
        end
    end

    // set wins over clear on the same bit
    assign mbox_nxt  = (mbox_q & ~mbox_clr) | mbox_set;
    assign latch_nxt = (latch_q & ~latch_clr) | bridge_evt_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '1;
            mbox_q  <= '0;
            latch_q <= '0;
            for (int i = 0; i < NUM_SRC; i++)
                map_q[i] <= '0;
        end else begin
            mbox_q  <= mbox_nxt;
            latch_q <= latch_nxt;
            if (wr_en_i && ctl_sel && (cw == CW_MASK))
                mask_q <= wdata_i[NUM_SRC-1:0];
            if (wr_en_i && map_sel)
                map_q[map_idx] <= wdata_i[MAP_W-1:0];
        end
    end

    // pending and status
    always_comb begin
        pending           = src_q_i | latch_q;
        pending[MBOX_SRC] = pending[MBOX_SRC] | (|mbox_q);
    end

    assign status = pending & ~mask_q;
    assign pick   = pick_highest(REG_W'(status));

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_flat
            assign map_flat[i*MAP_W +: MAP_W] = map_q[i];
        end
    endgenerate

    irqmap_route #(
        .NUM_SRC   (NUM_SRC),
        .NUM_LINES (NUM_LINES),
        .MAP_W     (MAP_W)
    ) i_route (
        .elig_i  (status),
        .codes_i (map_flat),
        .lines_o (lines_o)
    );

    // register read
    always_comb begin
        rdata_o = '0;
        if (map_sel) begin
            rdata_o[MAP_W-1:0] = map_q[map_idx];
        end else if (ctl_sel) begin
            unique case (cw)
                CW_MASK:   rdata_o = REG_W'(mask_q);
                CW_STATUS: rdata_o = REG_W'(status);
                CW_MBOX:   rdata_o = mbox_q;
                CW_LATCH:  rdata_o = REG_W'(latch_q);
                CW_TOP:    rdata_o = pack_pick(pick);
                default:   rdata_o = '0;
            endcase
        end
    end

    assign mask_o   = mask_q;
    assign mbox_o   = mbox_q;
    assign latch_o  = latch_q;
    assign status_o = status;

endmodule

// File: rtl/irqmap_top.sv
module irqmap_top
    import irqmap_pkg::*;
#(
    parameter int NUM_SRC   = 64,
    parameter int NUM_CPU   = 2,
    parameter int NUM_LINES = 5,
    parameter int MBOX_SRC  = 26,
    localparam int SRC_W    = $clog2(NUM_SRC),
    localparam int WIN_W    = SRC_W + 4,
    localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int ADDR_W   = WIN_W + CPU_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_SRC-1:0]           src_i,
    input  logic [NUM_SRC-1:0]           bridge_evt_i,
    input  logic                         reg_wr_i,
    input  logic [ADDR_W-1:0]            reg_addr_i,
    input  logic [REG_W-1:0]             reg_wdata_i,
    output logic [REG_W-1:0]             reg_rdata_o,
    output logic [NUM_CPU*NUM_LINES-1:0] irq_line_o
);

    logic [NUM_SRC-1:0]         src_q;
    logic [CPU_W-1:0]           cpu_sel;
    logic [REG_W-1:0]           slice_rd [NUM_CPU];
    logic [NUM_CPU*NUM_SRC-1:0] mask_all;
    logic [NUM_CPU*REG_W-1:0]   mbox_all;
    logic [NUM_CPU*NUM_SRC-1:0] latch_all;
    logic [NUM_CPU*NUM_SRC-1:0] status_all;

    assign cpu_sel = reg_addr_i[WIN_W +: CPU_W];

    // one register stage on the raw sources
    always_ff @(posedge clk) begin
        if (rst) src_q <= '0;
        else     src_q <= src_i;
    end

    generate
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
            logic wr_en;
            assign wr_en = reg_wr_i && (cpu_sel == CPU_W'(c));

            irqmap_cpu_slice #(
                .NUM_SRC   (NUM_SRC),
                .NUM_LINES (NUM_LINES),
                .MBOX_SRC  (MBOX_SRC)
            ) i_slice (
                .clk          (clk),
                .rst          (rst),
                .wr_en_i      (wr_en),
                .offset_i     (reg_addr_i[WIN_W-1:0]),
                .wdata_i      (reg_wdata_i),
                .src_q_i      (src_q),
                .bridge_evt_i (bridge_evt_i),
                .rdata_o      (slice_rd[c]),
                .mask_o       (mask_all[c*NUM_SRC +: NUM_SRC]),
                .mbox_o       (mbox_all[c*REG_W +: REG_W]),
                .latch_o      (latch_all[c*NUM_SRC +: NUM_SRC]),
                .status_o     (status_all[c*NUM_SRC +: NUM_SRC]),
                .lines_o      (irq_line_o[c*NUM_LINES +: NUM_LINES])
            );
        end
    endgenerate

    always_comb begin
        reg_rdata_o = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (cpu_sel == CPU_W'(c))
                reg_rdata_o = slice_rd[c];
        end
    end

endmodule

// File: rtl/irqmap_checker.sv
module irqmap_checker #(
    parameter int NUM_SRC   = 64,
    parameter int NUM_CPU   = 2,
    parameter int NUM_LINES = 5,
    localparam int SRC_W    = $clog2(NUM_SRC),
    localparam int WIN_W    = SRC_W + 4,
    localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int ADDR_W   = WIN_W + CPU_W
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         reg_wr_i,
    input logic [ADDR_W-1:0]            reg_addr_i,
    input logic [63:0]                  reg_wdata_i,
    input logic [NUM_SRC-1:0]           bridge_evt_i,
    input logic [NUM_CPU*NUM_LINES-1:0] irq_line_o,
    input logic [NUM_CPU*NUM_SRC-1:0]   mask_all,
    input logic [NUM_CPU*64-1:0]        mbox_all,
    input logic [NUM_CPU*NUM_SRC-1:0]   latch_all,
    input logic [NUM_CPU*NUM_SRC-1:0]   status_all
);

    logic [CPU_W-1:0] sel;
    logic [WIN_W-1:0] ofs;
    assign sel = reg_addr_i[WIN_W +: CPU_W];
    assign ofs = reg_addr_i[WIN_W-1:0];

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (irq_line_o == '0)); // R1

    generate
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
            AST_LINE_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
                (|irq_line_o[c*NUM_LINES +: NUM_LINES]) |-> (|status_all[c*NUM_SRC +: NUM_SRC])); // R4

            AST_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
                (reg_wr_i && sel == CPU_W'(c) && ofs == WIN_W'(0))
                |=> (mask_all[c*NUM_SRC +: NUM_SRC] == $past(reg_wdata_i[NUM_SRC-1:0]))); // R2

            AST_MBOX_FLUSH: assert property (@(posedge clk) disable iff (rst)
                (reg_wr_i && sel == CPU_W'(c) && ofs == WIN_W'(32) && reg_wdata_i == '1)
                |=> (mbox_all[c*64 +: 64] == '0)); // R6

            AST_LATCH_SET_WINS: assert property (@(posedge clk) disable iff (rst)
                (|bridge_evt_i)
                |=> ((latch_all[c*NUM_SRC +: NUM_SRC] & $past(bridge_evt_i)) == $past(bridge_evt_i))); // R7

            AST_OTHER_WINDOW: assert property (@(posedge clk) disable iff (rst)
                (reg_wr_i && sel != CPU_W'(c))
                |=> $stable(mask_all[c*NUM_SRC +: NUM_SRC])); // R8
        end
    endgenerate

endmodule

bind irqmap_top irqmap_checker #(
    .NUM_SRC   (NUM_SRC),
    .NUM_CPU   (NUM_CPU),
    .NUM_LINES (NUM_LINES)
) i_irqmap_checker (
    .clk          (clk),
    .rst          (rst),
    .reg_wr_i     (reg_wr_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .bridge_evt_i (bridge_evt_i),
    .irq_line_o   (irq_line_o),
    .mask_all     (mask_all),
    .mbox_all     (mbox_all),
    .latch_all    (latch_all),
    .status_all   (status_all)
);

// File: tb/test_irqmap_top.sv
`timescale 1ns/1ps
module test_irqmap_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src_i = '0;
    logic [63:0] bridge_evt_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [10:0] reg_addr_i = '0;
    logic [63:0] reg_wdata_i = '0;
    logic [63:0] reg_rdata_o;
    logic [9:0]  irq_line_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [2:0]  mdl_map  [2][64];
    logic [63:0] mdl_mask [2];

    always #5 clk = ~clk;

    irqmap_top i_irqmap_top (
        .clk          (clk),
        .rst          (rst),
        .src_i        (src_i),
        .bridge_evt_i (bridge_evt_i),
        .reg_wr_i     (reg_wr_i),
        .reg_addr_i   (reg_addr_i),
        .reg_wdata_i  (reg_wdata_i),
        .reg_rdata_o  (reg_rdata_o),
        .irq_line_o   (irq_line_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int cpu, input int ofs, input logic [63:0] d);
        @(negedge clk);
        reg_wr_i    = 1'b1;
        reg_addr_i  = {cpu[0], ofs[9:0]};
        reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i    = 1'b0;
    endtask

    task automatic rd(input int cpu, input int ofs, output logic [63:0] d);
        reg_addr_i = {cpu[0], ofs[9:0]};
        #1;
        d = reg_rdata_o;
    endtask

    function automatic logic [4:0] exp_cpu(input int c, input logic [63:0] pend);
        logic [4:0] r;
        r = '0;
        for (int i = 0; i < 64; i++)
            if (pend[i] && !mdl_mask[c][i] && mdl_map[c][i] < 3'd5)
                r[mdl_map[c][i]] = 1'b1;
        return r;
    endfunction

    function automatic logic [63:0] exp_top(input logic [63:0] st);
        logic [63:0] w;
        w = '0;
        for (int i = 0; i < 64; i++)
            if (st[i]) begin
                w = '0;
                w[8] = 1'b1;
                w[5:0] = 6'(i);
            end
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] d, m0, m1, p, st0, st1;
        logic [9:0]  prev;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 lines", 64'(irq_line_o), 64'h0);
        for (int c = 0; c < 2; c++) begin
            rd(c, 'h000, d); check("R1 mask", d, '1);
            rd(c, 'h010, d); check("R1 mbox", d, 64'h0);
            rd(c, 'h028, d); check("R1 latch", d, 64'h0);
            rd(c, 'h038, d); check("R1 top", d, 64'h0);
            rd(c, 'h200 + 8*63, d); check("R1 map", d, 64'h0);
            mdl_mask[c] = '1;
        end

        // R3 program every map code, upper data bits ignored
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 64; i++) begin
                mdl_map[c][i] = (c == 0) ? 3'(i % 6) : 3'((i * 3 + 1) % 8);
                wr(c, 'h200 + 8*i, {61'h0ABCDEF012345678, mdl_map[c][i]});
            end
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 64; i++) begin
                rd(c, 'h200 + 8*i, d);
                check("R3 map readback", d, 64'(mdl_map[c][i]));
            end

        // R2 unmask all; R8 misaligned write ignored
        wr(0, 'h004, 64'h0);
        rd(0, 'h000, d); check("R8 misaligned", d, '1);
        wr(0, 'h000, 64'h0); mdl_mask[0] = '0;
        rd(1, 'h000, d); check("R8 other window mask", d, '1);
        wr(1, 'h000, 64'h0); mdl_mask[1] = '0;

        // R4 single-source sweep with latency check
        prev = '0;
        for (int s = 0; s < 64; s++) begin
            @(negedge clk);
            src_i = 64'h1 << s;
            #1;
            check("R4 latency hold", 64'(irq_line_o), 64'(prev));
            @(negedge clk);
            prev = {exp_cpu(1, src_i), exp_cpu(0, src_i)};
            check("R3 R4 route", 64'(irq_line_o), 64'(prev));
            rd(0, 'h008, d); check("R5 status", d, src_i);
            rd(1, 'h038, d); check("R9 top", d, exp_top(src_i));
        end

        // R2 R5 R9 mask patterns, independent per processor
        for (int q = 0; q < 16; q++) begin
            m0 = 64'h9E3779B97F4A7C15 * 64'(q + 1);
            m1 = {m0[20:0], m0[63:21]} ^ 64'hF0F0_0FF0_33CC_5A5A;
            p  = 64'hC2B2AE3D27D4EB4F * 64'(q + 7);
            wr(0, 'h000, m0); mdl_mask[0] = m0;
            wr(1, 'h000, m1); mdl_mask[1] = m1;
            @(negedge clk);
            src_i = p;
            @(negedge clk);
            check("R2 R4 lines", 64'(irq_line_o), 64'({exp_cpu(1, p), exp_cpu(0, p)}));
            st0 = p & ~m0;
            st1 = p & ~m1;
            rd(0, 'h008, d); check("R5 status cpu0", d, st0);
            rd(1, 'h008, d); check("R5 status cpu1", d, st1);
            rd(0, 'h038, d); check("R9 top cpu0", d, exp_top(st0));
            rd(1, 'h038, d); check("R9 top cpu1", d, exp_top(st1));
        end

        // R6 mailbox on processor 1 only
        @(negedge clk); src_i = '0;
        wr(0, 'h000, '1); mdl_mask[0] = '1;
        wr(1, 'h000, ~(64'h1 << 26)); mdl_mask[1] = ~(64'h1 << 26);
        wr(1, 'h200 + 8*26, 64'd2); mdl_map[1][26] = 3'd2;
        check("R6 idle", 64'(irq_line_o), 64'h0);
        wr(1, 'h018, 64'h8000_0000_0000_0001);
        rd(1, 'h010, d); check("R6 mbox set", d, 64'h8000_0000_0000_0001);
        rd(0, 'h010, d); check("R8 mbox other", d, 64'h0);
        check("R6 mbox line", 64'(irq_line_o), 64'h1 << 7);
        rd(1, 'h008, d); check("R5 R6 mbox status", d, 64'h1 << 26);
        wr(1, 'h020, 64'h1);
        rd(1, 'h010, d); check("R6 partial clear", d, 64'h8000_0000_0000_0000);
        check("R6 line stays", 64'(irq_line_o), 64'h1 << 7);
        wr(1, 'h020, '1);
        rd(1, 'h010, d); check("R6 full clear", d, 64'h0);
        check("R6 line drops", 64'(irq_line_o), 64'h0);

        // R7 bridged latch
        wr(0, 'h000, 64'h0); mdl_mask[0] = '0;
        wr(1, 'h000, 64'h0); mdl_mask[1] = '0;
        @(negedge clk);
        bridge_evt_i = (64'h1 << 5) | (64'h1 << 40);
        @(negedge clk);
        bridge_evt_i = '0;
        rd(0, 'h028, d); check("R7 latch cpu0", d, bridge_evt_i | (64'h1 << 5) | (64'h1 << 40));
        rd(1, 'h028, d); check("R7 latch cpu1", d, (64'h1 << 5) | (64'h1 << 40));
        p = (64'h1 << 5) | (64'h1 << 40);
        check("R7 latch lines", 64'(irq_line_o), 64'({exp_cpu(1, p), exp_cpu(0, p)}));
        wr(0, 'h030, 64'h1 << 40);
        rd(0, 'h028, d); check("R7 clear cpu0", d, 64'h1 << 5);
        rd(1, 'h028, d); check("R8 latch other", d, p);
        // same-cycle event and clear on processor 0
        @(negedge clk);
        bridge_evt_i = 64'h1 << 40;
        reg_wr_i     = 1'b1;
        reg_addr_i   = {1'b0, 10'h030};
        reg_wdata_i  = p;
        @(negedge clk);
        bridge_evt_i = '0;
        reg_wr_i     = 1'b0;
        rd(0, 'h028, d); check("R7 set wins", d, 64'h1 << 40);
        rd(1, 'h028, d); check("R7 other latch", d, p);
        wr(0, 'h030, '1);
        wr(1, 'h030, '1);
        rd(0, 'h028, d); check("R7 flush cpu0", d, 64'h0);
        rd(1, 'h028, d); check("R7 flush cpu1", d, 64'h0);
        check("R7 quiet", 64'(irq_line_o), 64'h0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule